// File: doc/BRIEF.md
# Group Request Priority Arbiter

This block collects save and restore requests for a set of descriptor groups and decides which group a downstream sequencer serves next. Requests reach it from two sources: single-cycle request pulses from a hardware power controller, and single-cycle software trigger pulses for each group. Each source and each operation has its own pending vector, so four vectors are kept in all: hardware save, hardware restore, software save and software restore.

Every group carries a 4-bit save priority and a 4-bit restore priority, where a smaller value is more urgent. The arbiter picks the most urgent eligible group, breaks ties by the lower group index, and issues one grant at a time together with the group index, the operation and whether software asked for it. It then holds the grant until the sequencer reports completion. Completion clears the served pending bits. It also raises a completion pulse if software had requested the served operation. A global switch stops new hardware requests from being captured. A group with both a save and a restore pending is reported as conflicting and is not served.

Top module: `grp_req_arbiter`

## Requirements
- R1: After reset, all four pending vectors, `busy`, `gnt_vld`, `sw_done` and `conflict` are zero.
- R2: A pulse on bit g of `hw_save_req`, `hw_rest_req`, `sw_save_trig` or `sw_rest_trig` sets bit g of the matching pending output on the following clock edge. Hardware pulses are captured only while `hw_req_off` is low.
- R3: While `hw_req_off` is high, hardware request pulses leave both hardware pending vectors unchanged, and software triggers are still captured.
- R4: Each group has a priority field at bits [4g+3:4g] of `save_prio` and of `rest_prio`, where 0 is the most urgent. A group with save pending competes with its save priority, and a group with restore pending competes with its restore priority. The lowest value wins.
- R5: Among eligible groups with equal priority, the lowest group index is granted.
- R6: A group whose `grp_en` bit is 0 is never granted, and its pending bits are kept until it is enabled and served.
- R7: A group with a save pending (from either source) and a restore pending (from either source) at the same time shows a 1 in `conflict[g]` and is not granted.
- R8: `gnt_vld` pulses for one cycle, one clock after the pending state that causes it, and only while `busy` is 0. `busy` rises with the grant and stays high until `seq_done`. `gnt_idx` and `gnt_op` hold steady while `busy` is high. The next grant comes no earlier than one clock after the completion edge.
- R9: `seq_done` while `busy` is high clears both the hardware and the software pending bit of the granted operation for the granted group. A trigger for that same bit in the same cycle leaves it set. `seq_done` while `busy` is low has no effect.
- R10: `sw_done` pulses for one cycle on the completion edge when the software pending bit of the served operation was set at grant time, and stays 0 otherwise.
- R11: `gnt_op` is 0 for save and 1 for restore. `gnt_sw` is 1 when the software pending bit of the granted operation is set at the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req_off | input | 1 | Global mask of hardware request capture |
| grp_en | input | 16 | Per-group enable |
| save_prio | input | 64 | Per-group save priority, 4 bits per group |
| rest_prio | input | 64 | Per-group restore priority, 4 bits per group |
| hw_save_req | input | 16 | Hardware save request pulses |
| hw_rest_req | input | 16 | Hardware restore request pulses |
| sw_save_trig | input | 16 | Software save trigger pulses |
| sw_rest_trig | input | 16 | Software restore trigger pulses |
| seq_done | input | 1 | Sequencer completion of the granted group |
| gnt_vld | output | 1 | One-cycle grant strobe |
| gnt_idx | output | 4 | Granted group index |
| gnt_op | output | 1 | Granted operation, 0 save, 1 restore |
| gnt_sw | output | 1 | Granted operation was requested by software |
| busy | output | 1 | A grant is outstanding |
| sw_done | output | 1 | Software-requested operation completed |
| conflict | output | 16 | Groups pending both save and restore |
| pend_hw_save | output | 16 | Hardware save pending vector |
| pend_hw_rest | output | 16 | Hardware restore pending vector |
| pend_sw_save | output | 16 | Software save pending vector |
| pend_sw_rest | output | 16 | Software restore pending vector |

## Verification
A corrupt pending vector shows on the `pend_*` and `conflict` outputs one clock after the request pulse. A wrong selection shows on `gnt_idx` and `gnt_op` at the next edge. A busy flag that is stuck or released too early shows as either a missing grant one cycle after `seq_done`, or a fresh `gnt_vld` while a grant is still outstanding. A wrong clear on completion shows in the pending outputs and in `sw_done` on the completion edge itself.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        OP_SAVE = 1'b0,
        OP_REST = 1'b1
    } op_e;
endpackage

// File: rtl/grp_pend_capture.sv
module grp_pend_capture #(
    parameter int unsigned NGRP = 16,
    parameter int unsigned IW   = $clog2(NGRP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_off,
    input  logic [NGRP-1:0] hw_save_req,
    input  logic [NGRP-1:0] hw_rest_req,
    input  logic [NGRP-1:0] sw_save_trig,
    input  logic [NGRP-1:0] sw_rest_trig,
    input  logic            clr_vld,
    input  logic [IW-1:0]   clr_idx,
    input  arb_pkg::op_e    clr_op,
    output logic [NGRP-1:0] hs,
    output logic [NGRP-1:0] hr,
    output logic [NGRP-1:0] ss,
    output logic [NGRP-1:0] sr
);
    import arb_pkg::*;

    typedef struct packed {
        logic [NGRP-1:0] hs;
        logic [NGRP-1:0] hr;
        logic [NGRP-1:0] ss;
        logic [NGRP-1:0] sr;
    } pend_t;

    pend_t pend_d, pend_q;
    logic [NGRP-1:0] hw_gate;

    assign hw_gate = {NGRP{~hw_off}};

    always_comb begin
        pend_d = pend_q;
        // completion clears first, so a same-cycle trigger survives
        if (clr_vld) begin
            if (clr_op == OP_SAVE) begin
                pend_d.hs[clr_idx] = 1'b0;
                pend_d.ss[clr_idx] = 1'b0;
            end else begin
                pend_d.hr[clr_idx] = 1'b0;
                pend_d.sr[clr_idx] = 1'b0;
            end
        end
        pend_d.hs = pend_d.hs | (hw_save_req & hw_gate);
        pend_d.hr = pend_d.hr | (hw_rest_req & hw_gate);
        pend_d.ss = pend_d.ss | sw_save_trig;
        pend_d.sr = pend_d.sr | sw_rest_trig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign hs = pend_q.hs;
    assign hr = pend_q.hr;
    assign ss = pend_q.ss;
    assign sr = pend_q.sr;

    // R3
    hw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_off |=> (((hs & ~$past(hs)) == '0) && ((hr & ~$past(hr)) == '0)));

    // R9
    clr_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && clr_op == OP_SAVE && !hw_save_req[clr_idx] && !sw_save_trig[clr_idx])
        |=> (!hs[$past(clr_idx)] && !ss[$past(clr_idx)]));

    // R9
    clr_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && clr_op == OP_REST && !hw_rest_req[clr_idx] && !sw_rest_trig[clr_idx])
        |=> (!hr[$past(clr_idx)] && !sr[$past(clr_idx)]));
endmodule

// File: rtl/grp_prio_pick.sv
module grp_prio_pick #(
    parameter int unsigned NGRP = 16,
    parameter int unsigned PW   = 4,
    parameter int unsigned IW   = $clog2(NGRP)
) (
    input  logic [NGRP-1:0]    hs,
    input  logic [NGRP-1:0]    hr,
    input  logic [NGRP-1:0]    ss,
    input  logic [NGRP-1:0]    sr,
    input  logic [NGRP-1:0]    grp_en,
    input  logic [NGRP*PW-1:0] save_prio,
    input  logic [NGRP*PW-1:0] rest_prio,
    output logic               sel_vld,
    output logic [IW-1:0]      sel_idx,
    output arb_pkg::op_e       sel_op,
    output logic               sel_sw,
    output logic [NGRP-1:0]    conflict
);
    import arb_pkg::*;

    logic [NGRP-1:0] sv, rv, elig;
    logic [PW-1:0]   key [NGRP];
    logic [PW-1:0]   best_key;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign sv[g]       = hs[g] | ss[g];
        assign rv[g]       = hr[g] | sr[g];
        assign conflict[g] = sv[g] & rv[g];
        assign elig[g]     = grp_en[g] & ~conflict[g] & (sv[g] | rv[g]);
        assign key[g]      = sv[g] ? save_prio[g*PW +: PW] : rest_prio[g*PW +: PW];
    end

    // strict compare in ascending index keeps the lowest index on ties
    always_comb begin
        sel_vld  = 1'b0;
        sel_idx  = '0;
        best_key = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (elig[g] && (!sel_vld || key[g] < best_key)) begin
                sel_vld  = 1'b1;
                sel_idx  = IW'(g);
                best_key = key[g];
            end
        end
    end

    assign sel_op = rv[sel_idx] ? OP_REST : OP_SAVE;
    assign sel_sw = (sel_op == OP_REST) ? sr[sel_idx] : ss[sel_idx];
endmodule

// File: rtl/grp_req_arbiter.sv
module grp_req_arbiter #(
    parameter int unsigned NGRP = 16,
    parameter int unsigned PW   = 4,
    parameter int unsigned IW   = $clog2(NGRP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_req_off,
    input  logic [NGRP-1:0]    grp_en,
    input  logic [NGRP*PW-1:0] save_prio,
    input  logic [NGRP*PW-1:0] rest_prio,
    input  logic [NGRP-1:0]    hw_save_req,
    input  logic [NGRP-1:0]    hw_rest_req,
    input  logic [NGRP-1:0]    sw_save_trig,
    input  logic [NGRP-1:0]    sw_rest_trig,
    input  logic               seq_done,
    output logic               gnt_vld,
    output logic [IW-1:0]      gnt_idx,
    output logic               gnt_op,
    output logic               gnt_sw,
    output logic               busy,
    output logic               sw_done,
    output logic [NGRP-1:0]    conflict,
    output logic [NGRP-1:0]    pend_hw_save,
    output logic [NGRP-1:0]    pend_hw_rest,
    output logic [NGRP-1:0]    pend_sw_save,
    output logic [NGRP-1:0]    pend_sw_rest
);
    import arb_pkg::*;

    typedef struct packed {
        logic          busy;
        logic          gnt_vld;
        logic [IW-1:0] idx;
        op_e           op;
        logic          sw;
        logic          sw_done;
    } st_t;

    st_t st_d, st_q;

    logic          sel_vld;
    logic [IW-1:0] sel_idx;
    op_e           sel_op;
    logic          sel_sw;
    logic          clr_vld;

    assign clr_vld = st_q.busy & seq_done;

    grp_pend_capture #(.NGRP(NGRP), .IW(IW)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_off       (hw_req_off),
        .hw_save_req  (hw_save_req),
        .hw_rest_req  (hw_rest_req),
        .sw_save_trig (sw_save_trig),
        .sw_rest_trig (sw_rest_trig),
        .clr_vld      (clr_vld),
        .clr_idx      (st_q.idx),
        .clr_op       (st_q.op),
        .hs           (pend_hw_save),
        .hr           (pend_hw_rest),
        .ss           (pend_sw_save),
        .sr           (pend_sw_rest)
    );

    grp_prio_pick #(.NGRP(NGRP), .PW(PW), .IW(IW)) u_pick (
        .hs        (pend_hw_save),
        .hr        (pend_hw_rest),
        .ss        (pend_sw_save),
        .sr        (pend_sw_rest),
        .grp_en    (grp_en),
        .save_prio (save_prio),
        .rest_prio (rest_prio),
        .sel_vld   (sel_vld),
        .sel_idx   (sel_idx),
        .sel_op    (sel_op),
        .sel_sw    (sel_sw),
        .conflict  (conflict)
    );

    always_comb begin
        st_d         = st_q;
        st_d.gnt_vld = 1'b0;
        st_d.sw_done = 1'b0;
        if (st_q.busy) begin
            if (seq_done) begin
                st_d.busy    = 1'b0;
                st_d.sw_done = st_q.sw;
            end
        end else if (sel_vld) begin
            st_d.busy    = 1'b1;
            st_d.gnt_vld = 1'b1;
            st_d.idx     = sel_idx;
            st_d.op      = sel_op;
            st_d.sw      = sel_sw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_vld = st_q.gnt_vld;
    assign gnt_idx = st_q.idx;
    assign gnt_op  = st_q.op;
    assign gnt_sw  = st_q.sw;
    assign busy    = st_q.busy;
    assign sw_done = st_q.sw_done;

    // R6
    sel_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> grp_en[sel_idx]);

    // R7
    sel_noconf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> !conflict[sel_idx]);

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> (!gnt_vld && busy));

    // R8
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(gnt_idx) && $stable(gnt_op)));

    // R10
    sw_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done |-> $past(busy && seq_done && gnt_sw));
endmodule

// File: tb/tb_grp_req_arbiter.sv
module tb_grp_req_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [63:0] P8 = 64'h8888_8888_8888_8888;

    typedef struct packed {
        logic [15:0] hs, hr, ss, sr, en;
        logic [63:0] sp, rp;
        logic [3:0]  eidx;
        logic        eop;
        logic        esw;
        logic [15:0] econf;
    } vec_t;

    // R4 R5 R6 R7 R11 covered by rows
    localparam vec_t VECS [NV] = '{
        '{16'h0008, 16'h0000, 16'h0020, 16'h0000, 16'hFFFF, P8, P8, 4'd3, 1'b0, 1'b0, 16'h0000},
        '{16'h0000, 16'h0004, 16'h0000, 16'h0400, 16'hFFFF, P8, 64'h8888_8188_8888_8988, 4'd10, 1'b1, 1'b1, 16'h0000},
        '{16'h0002, 16'h0000, 16'h0000, 16'h0010, 16'hFFFF, 64'h8888_8888_8888_8828, 64'h8888_8888_8883_88F8, 4'd1, 1'b0, 1'b0, 16'h0000},
        '{16'h0081, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 64'h8888_8888_8888_8880, P8, 4'd7, 1'b0, 1'b0, 16'h0000},
        '{16'h0002, 16'h0000, 16'h0200, 16'h0002, 16'hFFFF, 64'h8888_8888_8888_8808, 64'h8888_8888_8888_8808, 4'd9, 1'b0, 1'b1, 16'h0002},
        '{16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'hFFFF, P8, P8, 4'd15, 1'b0, 1'b1, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_req_off = 1'b0;
    logic [15:0] grp_en = 16'hFFFF;
    logic [63:0] save_prio = P8, rest_prio = P8;
    logic [15:0] hw_save_req = '0, hw_rest_req = '0, sw_save_trig = '0, sw_rest_trig = '0;
    logic        seq_done = 1'b0;
    logic        gnt_vld, gnt_op, gnt_sw, busy, sw_done;
    logic [3:0]  gnt_idx;
    logic [15:0] conflict, pend_hw_save, pend_hw_rest, pend_sw_save, pend_sw_rest;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_req_arbiter dut (
        .clk(clk), .rst_n(rst_n), .hw_req_off(hw_req_off), .grp_en(grp_en),
        .save_prio(save_prio), .rest_prio(rest_prio),
        .hw_save_req(hw_save_req), .hw_rest_req(hw_rest_req),
        .sw_save_trig(sw_save_trig), .sw_rest_trig(sw_rest_trig),
        .seq_done(seq_done), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .gnt_op(gnt_op),
        .gnt_sw(gnt_sw), .busy(busy), .sw_done(sw_done), .conflict(conflict),
        .pend_hw_save(pend_hw_save), .pend_hw_rest(pend_hw_rest),
        .pend_sw_save(pend_sw_save), .pend_sw_rest(pend_sw_rest)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hw_save_req = '0; hw_rest_req = '0; sw_save_trig = '0; sw_rest_trig = '0;
        seq_done = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1", "pend_hw_save", pend_hw_save, 0);
        chk("R1", "pend_hw_rest", pend_hw_rest, 0);
        chk("R1", "pend_sw_save", pend_sw_save, 0);
        chk("R1", "pend_sw_rest", pend_sw_rest, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "gnt_vld", gnt_vld, 0);
        chk("R1", "sw_done", sw_done, 0);
        chk("R1", "conflict", conflict, 0);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] m;
            do_reset();
            grp_en = VECS[v].en;
            save_prio = VECS[v].sp;
            rest_prio = VECS[v].rp;
            hw_save_req = VECS[v].hs; hw_rest_req = VECS[v].hr;
            sw_save_trig = VECS[v].ss; sw_rest_trig = VECS[v].sr;
            tick();
            hw_save_req = '0; hw_rest_req = '0; sw_save_trig = '0; sw_rest_trig = '0;
            // R2 capture
            chk("R2", "pend_hw_save", pend_hw_save, VECS[v].hs);
            chk("R2", "pend_hw_rest", pend_hw_rest, VECS[v].hr);
            chk("R2", "pend_sw_save", pend_sw_save, VECS[v].ss);
            chk("R2", "pend_sw_rest", pend_sw_rest, VECS[v].sr);
            chk("R7", "conflict", conflict, VECS[v].econf);
            chk("R8", "gnt_vld before grant", gnt_vld, 0);
            tick();
            // R4 R5 R6 R7 grant choice, R11 fields
            chk("R8", "gnt_vld", gnt_vld, 1);
            chk("R4", "gnt_idx", gnt_idx, VECS[v].eidx);
            chk("R11", "gnt_op", gnt_op, VECS[v].eop);
            chk("R11", "gnt_sw", gnt_sw, VECS[v].esw);
            chk("R8", "busy", busy, 1);
            seq_done = 1'b1;
            tick();
            seq_done = 1'b0;
            m = ~(16'h1 << VECS[v].eidx);
            // R9 clear, R10 completion pulse
            chk("R10", "sw_done", sw_done, VECS[v].esw);
            chk("R8", "busy after done", busy, 0);
            chk("R9", "pend_hw_save", pend_hw_save, VECS[v].eop ? VECS[v].hs : (VECS[v].hs & m));
            chk("R9", "pend_sw_save", pend_sw_save, VECS[v].eop ? VECS[v].ss : (VECS[v].ss & m));
            chk("R9", "pend_hw_rest", pend_hw_rest, VECS[v].eop ? (VECS[v].hr & m) : VECS[v].hr);
            chk("R9", "pend_sw_rest", pend_sw_rest, VECS[v].eop ? (VECS[v].sr & m) : VECS[v].sr);
        end

        // R3 hardware mask
        do_reset();
        grp_en = 16'hFFFF; save_prio = P8; rest_prio = P8;
        hw_req_off = 1'b1;
        hw_save_req = 16'h0010; hw_rest_req = 16'h0020; sw_rest_trig = 16'h0040;
        tick();
        hw_save_req = '0; hw_rest_req = '0; sw_rest_trig = '0;
        chk("R3", "pend_hw_save masked", pend_hw_save, 0);
        chk("R3", "pend_hw_rest masked", pend_hw_rest, 0);
        chk("R3", "pend_sw_rest kept", pend_sw_rest, 16'h0040);
        tick();
        chk("R3", "grant idx sw only", gnt_idx, 6);
        hw_req_off = 1'b0;

        // R8 R9 R10 busy hold, same-cycle retrigger, next grant timing
        do_reset();
        rest_prio = 64'h8880_8888_8888_8888;
        sw_save_trig = 16'h0044;
        tick();
        sw_save_trig = '0;
        tick();
        chk("R8", "first grant vld", gnt_vld, 1);
        chk("R5", "first grant idx", gnt_idx, 2);
        hw_rest_req = 16'h1000;
        tick();
        hw_rest_req = '0;
        for (int k = 0; k < 3; k++) begin
            chk("R8", "no grant while busy", gnt_vld, 0);
            chk("R8", "idx held", gnt_idx, 2);
            chk("R8", "busy held", busy, 1);
            if (k < 2) tick();
        end
        seq_done = 1'b1;
        sw_save_trig = 16'h0004;
        tick();
        seq_done = 1'b0;
        sw_save_trig = '0;
        chk("R10", "sw_done after sw grant", sw_done, 1);
        chk("R9", "retrigger kept", pend_sw_save, 16'h0044);
        chk("R8", "no grant at done edge", gnt_vld, 0);
        tick();
        chk("R8", "next grant vld", gnt_vld, 1);
        chk("R4", "restore prio wins", gnt_idx, 12);
        chk("R11", "restore op", gnt_op, 1);
        chk("R11", "hw source", gnt_sw, 0);
        seq_done = 1'b1;
        tick();
        seq_done = 1'b0;
        chk("R10", "no sw_done for hw grant", sw_done, 0);
        chk("R9", "hw restore cleared", pend_hw_rest, 0);
        tick();
        chk("R5", "tie to lowest index", gnt_idx, 2);

        // R6 R9 disabled group, done while idle ignored
        do_reset();
        rest_prio = P8;
        grp_en = 16'hFFF7;
        sw_save_trig = 16'h0008;
        tick();
        sw_save_trig = '0;
        tick();
        chk("R6", "disabled not granted", gnt_vld, 0);
        chk("R6", "disabled not busy", busy, 0);
        seq_done = 1'b1;
        tick();
        seq_done = 1'b0;
        chk("R9", "idle done ignored", pend_sw_save, 16'h0008);
        chk("R10", "idle done no sw_done", sw_done, 0);
        grp_en = 16'hFFFF;
        tick();
        chk("R6", "granted once enabled", gnt_vld, 1);
        chk("R6", "granted idx", gnt_idx, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule